// File: doc/BRIEF.md
# Serial EEPROM transaction controller

This block is the transaction layer of a two-wire serial memory slave. It sits behind a bus front end that finds START and STOP conditions, matches the device address and moves whole bytes on and off the wire. The block models a 256 x 8 byte store in a register array. It keeps the internal address pointer and decodes the write and read transfers: single and multi-byte writes, reads from the current pointer, random reads, and sequential reads.

Write data is collected in a 16-byte page buffer. The buffer is committed to the array only when a STOP closes the write transfer. A timed write cycle follows. For its whole length the block raises `busy`. The front end uses `busy` to withhold the acknowledge of the device address, so a host can poll until the device answers again. Read bytes are handed to the front end one clock after each request.

Top module: `eeprom_txn_ctrl`

## Requirements
- R1: After reset `busy` and `tx_valid` are low, every array byte holds the erased value 0xFF, and the address pointer is 0.
- R2: In a write transfer (address event with `addr_rw`=0), the first received byte loads the address pointer, and each byte after it is a data byte for the location the pointer names.
- R3: After each data byte the low four pointer bits increment modulo 16 and the upper four bits keep their value, so one transfer only writes inside one 16-byte page.
- R4: When more than 16 data bytes arrive before the STOP, the page offset wraps, and a later byte replaces the earlier byte buffered at the same offset.
- R5: Buffered bytes reach the array all at once, at the STOP that ends a write transfer holding at least one data byte. A START before that STOP discards the buffered bytes.
- R6: `busy` rises the cycle after the committing STOP and stays high for exactly TWR_CYCLES cycles. While it is high, address events, received bytes and read requests have no effect.
- R7: A read transfer (address event with `addr_rw`=1) with no new address returns the byte at the current pointer. The pointer is the last read address plus one, or the in-page successor of the last written byte.
- R8: A write transfer that carries only the word address, followed by a repeated START and a read transfer, returns data starting at that new address.
- R9: In a read transfer each request increments the full 8-bit pointer, so a run of reads crosses page borders and wraps from 255 to 0.
- R10: A write transfer that carries only the word address updates the pointer but commits nothing and leaves `busy` low.
- R11: A read request during a read transfer while not busy produces `tx_valid` for one cycle with `tx_data` on the next clock. `tx_valid` never appears without a request the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_start | input | 1 | One-cycle pulse: START or repeated START seen |
| bus_stop | input | 1 | One-cycle pulse: STOP seen |
| addr_hit | input | 1 | One-cycle pulse: device address matched |
| addr_rw | input | 1 | Direction bit of the matched address, 1 = read |
| rx_valid | input | 1 | One-cycle pulse: a whole byte was received |
| rx_data | input | 8 | Received byte |
| tx_req | input | 1 | One-cycle pulse: front end needs the next byte to send |
| tx_valid | output | 1 | Read byte is present on tx_data |
| tx_data | output | 8 | Byte to send |
| busy | output | 1 | Write cycle in progress; front end must not acknowledge |

## Verification
The assertions check several properties on every cycle. A committing STOP always raises `busy`. A STOP after an address-only write never does. The commit pulse never arrives while busy, and state stays frozen under address events while busy. Each read request yields `tx_valid`, and the pointer steps by one in reads. Received data bytes never move the page bits of the pointer.

Only the bench scenarios can show where bytes land and what reads return. That covers the in-page wrap, overwriting past 16 bytes, the byte stream read across the 255-to-0 wrap, and the discarding effect of a repeated START. The bench also measures the exact busy length and confirms that stimulus sent during busy leaves the array unchanged.

// File: rtl/eeprom_txn_pkg.sv
package eeprom_txn_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for an address event
        ST_WADDR = 2'd1,   // write transfer, expecting word address
        ST_WDATA = 2'd2,   // write transfer, taking data bytes
        ST_READ  = 2'd3    // read transfer, serving requests
    } txn_state_e;
endpackage

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
    parameter int PAGE_BYTES = 16,
    parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    wr_en,
    input  logic [OFF_W-1:0]        wr_off,
    input  logic [7:0]              wr_data,
    output logic [PAGE_BYTES*8-1:0] page_data,
    output logic [PAGE_BYTES-1:0]   page_mask
);
    typedef struct packed {
        logic [PAGE_BYTES*8-1:0] data;
        logic [PAGE_BYTES-1:0]   mask;
    } pbuf_t;

    pbuf_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (clear) begin
            nxt_d.mask = '0;
        end else if (wr_en) begin
            nxt_d.data[wr_off*8 +: 8] = wr_data;
            nxt_d.mask[wr_off]        = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign page_data = cur_q.data;
    assign page_mask = cur_q.mask;

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (page_mask == '0)) else $error("buffer not cleared"); // R5
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
    parameter int       ADDR_W     = 8,
    parameter int       PAGE_BYTES = 16,
    parameter logic [7:0] ERASED   = 8'hFF,
    parameter int       OFF_W      = $clog2(PAGE_BYTES),
    parameter int       PAGE_W     = ADDR_W - OFF_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit,
    input  logic [PAGE_W-1:0]       page,
    input  logic [PAGE_BYTES*8-1:0] page_data,
    input  logic [PAGE_BYTES-1:0]   page_mask,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [7:0]              rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_q [DEPTH];
    logic [7:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (page_mask[i])
                    mem_d[{page, OFF_W'(i)}] = page_data[i*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < DEPTH; j++) mem_q[j] <= ERASED;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/eeprom_wr_timer.sv
module eeprom_wr_timer #(
    parameter int TWR_CYCLES = 1_000_000,
    parameter int CNT_W      = $clog2(TWR_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic busy
);
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (launch)           cnt_d = CNT_W'(TWR_CYCLES);
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !busy) else $error("write cycle relaunched while busy"); // R6
    AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy) else $error("launch did not raise busy"); // R6
endmodule

// File: rtl/eeprom_txn_ctrl.sv
module eeprom_txn_ctrl #(
    parameter int         ADDR_W     = 8,
    parameter int         PAGE_BYTES = 16,
    parameter int         TWR_CYCLES = 1_000_000,
    parameter logic [7:0] ERASED     = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic       addr_hit,
    input  logic       addr_rw,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       tx_req,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       busy
);
    import eeprom_txn_pkg::*;

    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFF_W;

    typedef struct packed {
        txn_state_e        state;
        logic [ADDR_W-1:0] ptr;
        logic [7:0]        txd;
        logic              txv;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic                    buf_clear, buf_wr, commit;
    logic [PAGE_BYTES*8-1:0] page_data;
    logic [PAGE_BYTES-1:0]   page_mask;
    logic [7:0]              rd_data;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.txv = 1'b0;
        buf_clear = 1'b0;
        buf_wr    = 1'b0;
        commit    = 1'b0;
        if (bus_stop) begin
            commit      = (ctl_q.state == ST_WDATA) && (page_mask != '0) && !busy;
            buf_clear   = 1'b1;
            ctl_d.state = ST_IDLE;
        end else if (bus_start) begin
            buf_clear   = 1'b1;
            ctl_d.state = ST_IDLE;
        end else if (!busy) begin
            if (addr_hit) begin
                buf_clear   = 1'b1;
                ctl_d.state = addr_rw ? ST_READ : ST_WADDR;
            end else if (rx_valid && ctl_q.state == ST_WADDR) begin
                ctl_d.ptr   = rx_data[ADDR_W-1:0];
                ctl_d.state = ST_WDATA;
            end else if (rx_valid && ctl_q.state == ST_WDATA) begin
                buf_wr    = 1'b1;
                ctl_d.ptr = {ctl_q.ptr[ADDR_W-1:OFF_W], ctl_q.ptr[OFF_W-1:0] + 1'b1};
            end else if (tx_req && ctl_q.state == ST_READ) begin
                ctl_d.txd = rd_data;
                ctl_d.txv = 1'b1;
                ctl_d.ptr = ctl_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= ST_IDLE;
            ctl_q.ptr   <= '0;
            ctl_q.txd   <= '0;
            ctl_q.txv   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    eeprom_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_pbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (buf_clear),
        .wr_en     (buf_wr),
        .wr_off    (ctl_q.ptr[OFF_W-1:0]),
        .wr_data   (rx_data),
        .page_data (page_data),
        .page_mask (page_mask)
    );

    eeprom_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .ERASED(ERASED)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .page      (ctl_q.ptr[ADDR_W-1:OFF_W]),
        .page_data (page_data),
        .page_mask (page_mask),
        .rd_addr   (ctl_q.ptr),
        .rd_data   (rd_data)
    );

    eeprom_wr_timer #(.TWR_CYCLES(TWR_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (commit),
        .busy   (busy)
    );

    assign tx_valid = ctl_q.txv;
    assign tx_data  = ctl_q.txd;

    AST_STOP_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stop && ctl_q.state == ST_WDATA && page_mask != '0 && !busy) |=> busy)
        else $error("STOP with data did not start write cycle"); // R5
    AST_ADDR_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stop && ctl_q.state == ST_WADDR && !busy) |=> !busy)
        else $error("address-only write started a cycle"); // R10
    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && addr_hit && !bus_start && !bus_stop) |=> $stable(ctl_q.state))
        else $error("address accepted while busy"); // R6
    AST_TX_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !busy && !bus_start && !bus_stop && !addr_hit && !rx_valid
         && ctl_q.state == ST_READ) |=> tx_valid)
        else $error("read request not served"); // R11
    AST_TX_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(tx_req))
        else $error("tx_valid without request"); // R11
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (ctl_q.ptr == $past(ctl_q.ptr) + 1'b1))
        else $error("read pointer did not step"); // R9
    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr) |=> (ctl_q.ptr[ADDR_W-1:OFF_W] == $past(ctl_q.ptr[ADDR_W-1:OFF_W])))
        else $error("data byte moved page bits"); // R3
endmodule

// File: tb/eeprom_txn_ctrl_tb.sv
module eeprom_txn_ctrl_tb;
    localparam int TWR = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_start = 0, bus_stop = 0, addr_hit = 0, addr_rw = 0;
    logic       rx_valid = 0, tx_req = 0;
    logic [7:0] rx_data = '0;
    logic       tx_valid, busy;
    logic [7:0] tx_data;

    int errors = 0;
    int checks = 0;
    logic [7:0] mdl_mem [256];
    logic [7:0] mdl_ptr;

    always #5 clk = ~clk;

    eeprom_txn_ctrl #(.TWR_CYCLES(TWR)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .addr_hit(addr_hit), .addr_rw(addr_rw), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_req(tx_req), .tx_valid(tx_valid), .tx_data(tx_data), .busy(busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic p_start();
        @(negedge clk); bus_start = 1; @(negedge clk); bus_start = 0;
    endtask
    task automatic p_stop();
        @(negedge clk); bus_stop = 1; @(negedge clk); bus_stop = 0;
    endtask
    task automatic p_addr(input logic rw);
        @(negedge clk); addr_hit = 1; addr_rw = rw; @(negedge clk); addr_hit = 0;
    endtask
    task automatic p_rx(input logic [7:0] b);
        @(negedge clk); rx_valid = 1; rx_data = b; @(negedge clk); rx_valid = 0;
    endtask
    task automatic p_tx(output logic v, output logic [7:0] d);
        @(negedge clk); tx_req = 1; @(negedge clk); tx_req = 0;
        v = tx_valid; d = tx_data;
    endtask

    // measure busy length right after a committing STOP
    task automatic wait_cycle(input string tag);
        int n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
        chk(tag, n, TWR);
    endtask

    // read n bytes in a read transfer, compare to model
    task automatic read_run(input string tag, input int n);
        logic v; logic [7:0] d;
        p_start(); p_addr(1'b1);
        for (int k = 0; k < n; k++) begin
            p_tx(v, d);
            chk({tag, " R11 valid"}, v, 1);
            chk(tag, d, mdl_mem[mdl_ptr]);
            mdl_ptr = mdl_ptr + 1;
        end
        p_stop();
    endtask

    // write transfer: address then n data bytes; bytes derived from seed
    task automatic write_run(input logic [7:0] a, input int n, input logic [7:0] seed, input bit do_stop);
        p_start(); p_addr(1'b0); p_rx(a);
        mdl_ptr = a;
        for (int k = 0; k < n; k++) begin
            logic [7:0] b = seed + 8'(k * 7);
            p_rx(b);
            if (do_stop) mdl_mem[mdl_ptr] = b;
            mdl_ptr = {mdl_ptr[7:4], mdl_ptr[3:0] + 4'd1};
        end
        if (do_stop) p_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic v; logic [7:0] d;
        for (int i = 0; i < 256; i++) mdl_mem[i] = 8'hFF;
        mdl_ptr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 tx_valid", tx_valid, 0);
        read_run("R1 erased at ptr 0", 2);

        // R10 address-only write
        p_start(); p_addr(1'b0); p_rx(8'h10); p_stop();
        mdl_ptr = 8'h10;
        repeat (3) @(negedge clk);
        chk("R10 no busy", busy, 0);
        read_run("R10 R7 pointer from address-only write", 1);

        // R2 single byte write
        write_run(8'h77, 1, 8'hC3, 1);
        wait_cycle("R6 busy length single");
        read_run("R2 R7 byte after single write", 1);
        p_start(); p_addr(1'b0); p_rx(8'h77); p_start(); p_addr(1'b1);
        mdl_ptr = 8'h77;
        p_tx(v, d); chk("R2 R8 single write stored", d, mdl_mem[8'h77]); mdl_ptr++;
        p_stop();

        // R3 R6 R7 sweep every page with a start offset of its page number
        for (int p = 0; p < 16; p++) begin
            write_run(8'(p * 16 + p), 16, 8'(p * 29 + 3), 1);
            wait_cycle("R6 busy length page");
            read_run("R3 R7 in-page wrap pointer", 1);
        end

        // R4 overflow: 20 bytes into page 3 from offset 2
        write_run(8'h32, 20, 8'h41, 1);
        wait_cycle("R6 busy length overflow");
        p_start(); p_addr(1'b0); p_rx(8'h30); mdl_ptr = 8'h30;
        read_run("R4 overwritten page", 16);

        // R6 stimulus during busy is ignored
        write_run(8'h55, 1, 8'h99, 1);
        p_start(); p_addr(1'b0); p_rx(8'h00); p_rx(8'hAA); p_stop();
        p_start(); p_addr(1'b1); p_tx(v, d);
        chk("R6 no read while busy", v, 0);
        p_stop();
        while (busy) @(negedge clk);
        p_start(); p_addr(1'b0); p_rx(8'h00); mdl_ptr = 8'h00;
        read_run("R6 R9 array after busy", 256);

        // R5 repeated START discards buffered data
        write_run(8'h40, 3, 8'h11, 0);
        p_start(); p_addr(1'b1);
        p_tx(v, d); chk("R5 read after abort", d, mdl_mem[mdl_ptr]); mdl_ptr++;
        p_stop();
        repeat (2) @(negedge clk);
        chk("R5 no cycle", busy, 0);
        p_start(); p_addr(1'b0); p_rx(8'h40); mdl_ptr = 8'h40;
        read_run("R5 R8 old data kept", 3);

        // R8 random reads
        for (int a = 5; a < 256; a += 37) begin
            p_start(); p_addr(1'b0); p_rx(8'(a)); mdl_ptr = 8'(a);
            read_run("R8 random read", 2);
        end

        // R9 sequential wrap 255 -> 0
        p_start(); p_addr(1'b0); p_rx(8'hF8); mdl_ptr = 8'hF8;
        read_run("R9 sequential wrap", 300);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule